// File: doc/BRIEF.md
# DMA Strobe Timing Generator

This block runs the peripheral side of a DMA transfer. When the peripheral raises its request and the channel is enabled, the block raises the acknowledge. The acknowledge stays high for exactly as long as the transfer lasts. Chip select is held low for that whole span. Each word is moved under a read or write strobe. Where the memory-side data goes, and which DMA channel wins arbitration, are decided outside this block.

The strobe timing comes from one of two sources. The first is a 4-bit DMA timing code, which also has a continuous mode in which the strobe stays low and one word moves per clock. The second is the per-channel PIO read and write low times. In wide mode each beat carries 32 bits: the upper half travels on the low address lines. A pause input stands for a memory refresh. While it is high the acknowledge and the strobes are withdrawn and the transfer is frozen, and the transfer continues where it stopped once the pause is released.

Top module: `dma_strobe_gen`

## Requirements
- R1: After reset the acknowledge is low, chip select, read strobe and write strobe are high, and neither the data lines nor the address lines are driven.
- R2: A request seen at a clock edge while enabled and idle raises the acknowledge in the cycle that follows, with the strobe low from that same cycle. The acknowledge falls in the cycle after the last low cycle of the final word, so a transfer of N words with low time L keeps the acknowledge high for N*L+N-1 cycles.
- R3: Chip select is low in exactly the cycles in which the acknowledge is high.
- R4: With DMA timing selected and a code v of 0 to 14, a write strobe is low for v+1 cycles. A read strobe is low for v+1 cycles, except that codes 0 and 1 both give 2 cycles. Consecutive words are separated by exactly one high cycle.
- R5: With DMA timing selected, code 15 keeps the strobe low for the whole transfer and moves one word per clock, so N words take N acknowledge cycles in a single strobe pulse.
- R6: With PIO timing selected, the read low time is the PIO read value plus one and the write low time is the PIO write value plus one, with a one-cycle high gap; the DMA code has no effect.
- R7: In wide mode, a read word is {addr_i, data_i} and the address lines are not driven during the transfer. A write drives the upper half of the word on addr_o and the lower half on data_o.
- R8: Outside wide mode, 16-bit access moves data bits 15:0. 8-bit access moves only bits 7:0, and the read result and the driven data carry zeros above bit 7. Wide mode overrides the access type.
- R9: While pause_i is high during a transfer, the acknowledge is low, chip select and both strobes are high, and no word completes. Afterwards the transfer resumes with its word count intact, so the number of unpaused acknowledge cycles equals that of an unpaused transfer.
- R10: A request is ignored while the channel is disabled or the word count is zero.
- R11: Direction, timing source, timing values, wide mode and access type are captured at the start. Changing them mid-transfer does not alter that transfer.
- R12: A read uses only the read strobe and never drives the data lines. A write uses only the write strobe and drives the data lines while the acknowledge is high. rvalid_o marks each completing read word and wnext_o each completing write word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Peripheral DMA request |
| chan_en_i | input | 1 | Channel enable |
| pause_i | input | 1 | Refresh pause; suspends the transfer |
| rd_dir_i | input | 1 | 1 = peripheral to memory (read), 0 = write |
| dma_tim_sel_i | input | 1 | 1 = DMA timing code, 0 = PIO timing |
| dma_tim_i | input | 4 | DMA timing code; 15 = continuous |
| pio_rd_tim_i | input | 4 | PIO read low time minus one |
| pio_wr_tim_i | input | 4 | PIO write low time minus one |
| wide_i | input | 1 | 32-bit wide beats |
| acc16_i | input | 1 | 1 = 16-bit access, 0 = 8-bit |
| word_cnt_i | input | 16 | Number of words to move |
| wdata_i | input | 32 | Word to write to the peripheral |
| rdata_o | output | 32 | Word read from the peripheral |
| rvalid_o | output | 1 | A read word completes at the next edge |
| wnext_o | output | 1 | A write word completes at the next edge |
| ack_o | output | 1 | DMA acknowledge |
| cs_n_o | output | 1 | Chip select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| data_o | output | 16 | Data lines, driven value |
| data_oe_o | output | 1 | Data line output enable |
| data_i | input | 16 | Data lines, received value |
| addr_o | output | 16 | Low address lines, driven value |
| addr_oe_o | output | 1 | Address line output enable |
| addr_i | input | 16 | Low address lines, received value |

## Verification
The acknowledge and the strobe change in the cycle right after the edge that samples the request. Each later strobe edge comes a whole number of cycles after that: L low cycles per word, one high cycle between words, and none in continuous mode. rvalid_o, wnext_o and the data views are combinational, so they are valid in the cycle before the edge that ends a word. The bench drives every input and takes every sample at the falling edge. It samples first and then drives. In this way each sample shows the state left by the previous rising edge, together with the pause level applied for that cycle. Cycle counts are compared with the N*L+N-1 formula, and strobe pulse widths and gaps are measured cycle by cycle.

// File: rtl/dma_strobe_gen.sv
module dma_strobe_gen #(
  parameter int CNT_W = 16,
  parameter int TIM_W = 4,
  parameter int BUS_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic               chan_en_i,
  input  logic               pause_i,
  input  logic               rd_dir_i,
  input  logic               dma_tim_sel_i,
  input  logic [TIM_W-1:0]   dma_tim_i,
  input  logic [TIM_W-1:0]   pio_rd_tim_i,
  input  logic [TIM_W-1:0]   pio_wr_tim_i,
  input  logic               wide_i,
  input  logic               acc16_i,
  input  logic [CNT_W-1:0]   word_cnt_i,
  input  logic [2*BUS_W-1:0] wdata_i,
  output logic [2*BUS_W-1:0] rdata_o,
  output logic               rvalid_o,
  output logic               wnext_o,
  output logic               ack_o,
  output logic               cs_n_o,
  output logic               rd_n_o,
  output logic               wr_n_o,
  output logic [BUS_W-1:0]   data_o,
  output logic               data_oe_o,
  input  logic [BUS_W-1:0]   data_i,
  output logic [BUS_W-1:0]   addr_o,
  output logic               addr_oe_o,
  input  logic [BUS_W-1:0]   addr_i
);
  localparam int LEN_W = TIM_W + 1;
  localparam int BYTE_W = 8;
  localparam logic [TIM_W-1:0] CONT_CODE = '1;
  localparam logic [1:0] S_IDLE = 2'd0, S_LOW = 2'd1, S_HIGH = 2'd2;

  logic [1:0]       state;
  logic [CNT_W-1:0] words_left;
  logic [LEN_W-1:0] low_left, len_q, len_in;
  logic             rd_q, wide_q, acc16_q, cont_q;

  logic [TIM_W-1:0] tim_pick;
  logic             rd_floor, cont_in, start, busy, beat_done, strobe;

  assign tim_pick = dma_tim_sel_i ? dma_tim_i : (rd_dir_i ? pio_rd_tim_i : pio_wr_tim_i);
  assign cont_in  = dma_tim_sel_i && (dma_tim_i == CONT_CODE);
  assign rd_floor = dma_tim_sel_i && rd_dir_i && (dma_tim_i == '0);
  assign len_in   = cont_in ? LEN_W'(1)
                            : LEN_W'(tim_pick) + LEN_W'(1) + LEN_W'(rd_floor);

  assign start     = (state == S_IDLE) && req_i && chan_en_i && (word_cnt_i != '0) && !pause_i;
  assign busy      = (state != S_IDLE);
  assign beat_done = (state == S_LOW) && !pause_i && (low_left == '0);
  assign strobe    = (state == S_LOW) && !pause_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      words_left <= '0;
      low_left   <= '0;
      len_q      <= '0;
      rd_q       <= 1'b0;
      wide_q     <= 1'b0;
      acc16_q    <= 1'b0;
      cont_q     <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state      <= S_LOW;
          words_left <= word_cnt_i;
          low_left   <= len_in - LEN_W'(1);
          len_q      <= len_in;
          rd_q       <= rd_dir_i;
          wide_q     <= wide_i;
          acc16_q    <= acc16_i;
          cont_q     <= cont_in;
        end
        S_LOW: if (!pause_i) begin
          if (low_left != '0) begin
            low_left <= low_left - LEN_W'(1);
          end else begin
            words_left <= words_left - CNT_W'(1);
            if (words_left == CNT_W'(1))
              state <= S_IDLE;
            else if (cont_q)
              low_left <= '0;
            else
              state <= S_HIGH;
          end
        end
        S_HIGH: if (!pause_i) begin
          state    <= S_LOW;
          low_left <= len_q - LEN_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign ack_o     = busy && !pause_i;
  assign cs_n_o    = !ack_o;
  assign rd_n_o    = !(strobe && rd_q);
  assign wr_n_o    = !(strobe && !rd_q);
  assign rvalid_o  = beat_done && rd_q;
  assign wnext_o   = beat_done && !rd_q;

  assign data_oe_o = ack_o && !rd_q;
  assign addr_oe_o = ack_o && !(wide_q && rd_q);

  assign rdata_o = wide_q  ? {addr_i, data_i} :
                   acc16_q ? {{BUS_W{1'b0}}, data_i} :
                             {{(2*BUS_W-BYTE_W){1'b0}}, data_i[BYTE_W-1:0]};

  assign data_o = !data_oe_o          ? '0 :
                  (wide_q || acc16_q) ? wdata_i[BUS_W-1:0] :
                                        {{(BUS_W-BYTE_W){1'b0}}, wdata_i[BYTE_W-1:0]};

  assign addr_o = (ack_o && wide_q && !rd_q) ? wdata_i[2*BUS_W-1:BUS_W] : '0;
endmodule

module dma_strobe_gen_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pause_i,
  input logic             ack_o,
  input logic             rd_n_o,
  input logic             wr_n_o,
  input logic [1:0]       state,
  input logic [CNT_W-1:0] words_left,
  input logic             cont_q
);
  // R12
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n_o && !wr_n_o));

  // R2
  strobe_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_o |-> (rd_n_o && wr_n_o));

  // R9
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_i && state != 2'd0) |=> $stable(words_left));

  // R5
  cont_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1 && cont_q && !pause_i && words_left > CNT_W'(1))
      |=> words_left == $past(words_left) - CNT_W'(1));

  // R4
  gap_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2 && !pause_i) |=> state == 2'd1);
endmodule

bind dma_strobe_gen dma_strobe_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pause_i(pause_i), .ack_o(ack_o),
  .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .state(state),
  .words_left(words_left), .cont_q(cont_q)
);

// File: tb/dma_strobe_gen_test.sv
`timescale 1ns/1ps
module dma_strobe_gen_test;
  logic clk = 0, rst_n = 0;
  logic req_i = 0, chan_en_i = 1, pause_i = 0, rd_dir_i = 1, dma_tim_sel_i = 1;
  logic [3:0] dma_tim_i = 0, pio_rd_tim_i = 0, pio_wr_tim_i = 0;
  logic wide_i = 0, acc16_i = 1;
  logic [15:0] word_cnt_i = 0;
  logic [31:0] wdata_i = 0, rdata_o;
  logic rvalid_o, wnext_o, ack_o, cs_n_o, rd_n_o, wr_n_o, data_oe_o, addr_oe_o;
  logic [15:0] data_o, data_i = 0, addr_o, addr_i = 0;

  int checks = 0, errors = 0;
  int ack_cyc, pulses, min_low, max_low, max_gap, beats, data_err, cs_err, dir_err, pause_err, adr_err;

  always #4 clk = ~clk;

  dma_strobe_gen uut (.*);

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int k);
    return (32'(k) * 32'h01030507) ^ 32'hC33C5AA5;
  endfunction

  task automatic xfer(input bit rd, input bit dsel, input logic [3:0] tim, input logic [3:0] prd,
                      input logic [3:0] pwr, input bit wide, input bit a16, input int n,
                      input int p_at, input int p_len, input bit tim_flip);
    int c = 0, k = 0, run = 0, gap = 0;
    bit seen = 0, prev_low = 0, low;
    logic [31:0] exp;
    ack_cyc = 0; pulses = 0; min_low = 1000; max_low = 0; max_gap = 0; beats = 0;
    data_err = 0; cs_err = 0; dir_err = 0; pause_err = 0; adr_err = 0;
    @(negedge clk);
    rd_dir_i = rd; dma_tim_sel_i = dsel; dma_tim_i = tim; pio_rd_tim_i = prd; pio_wr_tim_i = pwr;
    wide_i = wide; acc16_i = a16; word_cnt_i = 16'(n); chan_en_i = 1;
    wdata_i = pat(0); data_i = pat(0)[15:0]; addr_i = pat(0)[31:16];
    req_i = 1;
    while (c < 2000) begin
      @(negedge clk); c++;
      if (cs_n_o != !ack_o) cs_err++;
      if (pause_i) begin
        if (ack_o || !rd_n_o || !wr_n_o || !cs_n_o || rvalid_o || wnext_o) pause_err++;
      end else begin
        if (ack_o) begin
          seen = 1; ack_cyc++;
          if (rd ? (!wr_n_o || data_oe_o) : (!rd_n_o || !data_oe_o)) dir_err++;
          if (wide && rd && addr_oe_o) adr_err++;
          if (wide && !rd && !addr_oe_o) adr_err++;
          low = rd ? !rd_n_o : !wr_n_o;
          if (low) begin
            if (!prev_low) begin pulses++; if (gap > max_gap) max_gap = gap; end
            run++; gap = 0;
          end else begin
            if (prev_low) begin
              if (run < min_low) min_low = run; if (run > max_low) max_low = run; run = 0;
            end
            gap++;
          end
          prev_low = low;
        end else if (seen) begin
          if (prev_low) begin if (run < min_low) min_low = run; if (run > max_low) max_low = run; end
          break;
        end
        if (rvalid_o) begin
          exp = wide ? pat(k) : a16 ? {16'h0, pat(k)[15:0]} : {24'h0, pat(k)[7:0]};
          if (rdata_o != exp) data_err++;
          k++; beats++;
          data_i = pat(k)[15:0]; addr_i = pat(k)[31:16];
        end
        if (wnext_o) begin
          if (data_o != ((wide || a16) ? pat(k)[15:0] : {8'h0, pat(k)[7:0]})) data_err++;
          if (wide && addr_o != pat(k)[31:16]) data_err++;
          k++; beats++;
          wdata_i = pat(k);
        end
      end
      if (ack_o) req_i = 0;
      pause_i = (p_at >= 0) && (c >= p_at) && (c < p_at + p_len);
      if (tim_flip && c == 2) dma_tim_i = 4'd9;
    end
    pause_i = 0; req_i = 0;
    check(c < 2000, "R2 transfer ended", c, 0);
  endtask

  task automatic t_reset;
    check(!ack_o && cs_n_o && rd_n_o && wr_n_o && !data_oe_o && !addr_oe_o, "R1 reset idle",
          {ack_o, cs_n_o, rd_n_o, wr_n_o, data_oe_o, addr_oe_o}, 6'b011100);
  endtask

  task automatic t_dma_read;
    xfer(1, 1, 4'd3, 0, 0, 0, 1, 3, -1, 0, 0);
    check(ack_cyc == 14, "R2 ack length", ack_cyc, 14);
    check(pulses == 3 && min_low == 4 && max_low == 4, "R4 low time 4", max_low, 4);
    check(max_gap == 1, "R4 one-cycle gap", max_gap, 1);
    check(beats == 3 && data_err == 0, "R8 16-bit read data", data_err, 0);
    check(cs_err == 0, "R3 chip select follows ack", cs_err, 0);
    check(dir_err == 0, "R12 read direction", dir_err, 0);
  endtask

  task automatic t_floor;
    xfer(1, 1, 4'd0, 0, 0, 0, 1, 2, -1, 0, 0);
    check(max_low == 2 && min_low == 2 && ack_cyc == 5, "R4 read code 0", max_low, 2);
    xfer(1, 1, 4'd1, 0, 0, 0, 1, 2, -1, 0, 0);
    check(max_low == 2 && min_low == 2, "R4 read code 1", max_low, 2);
    xfer(0, 1, 4'd0, 0, 0, 0, 1, 2, -1, 0, 0);
    check(max_low == 1 && ack_cyc == 3, "R4 write code 0", max_low, 1);
    xfer(0, 1, 4'd1, 0, 0, 0, 1, 2, -1, 0, 0);
    check(max_low == 2 && ack_cyc == 5, "R4 write code 1", max_low, 2);
    check(dir_err == 0 && data_err == 0, "R12 write direction", dir_err, 0);
  endtask

  task automatic t_cont;
    xfer(1, 1, 4'd15, 0, 0, 0, 1, 5, -1, 0, 0);
    check(ack_cyc == 5 && pulses == 1 && max_low == 5, "R5 continuous read", ack_cyc, 5);
    check(beats == 5 && data_err == 0, "R5 continuous read data", beats, 5);
    xfer(0, 1, 4'd15, 0, 0, 1, 1, 4, -1, 0, 0);
    check(ack_cyc == 4 && beats == 4 && data_err == 0, "R5 continuous wide write", ack_cyc, 4);
  endtask

  task automatic t_pio;
    xfer(1, 0, 4'd7, 4'd2, 4'd9, 0, 1, 2, -1, 0, 0);
    check(max_low == 3 && min_low == 3 && ack_cyc == 7, "R6 PIO read", max_low, 3);
    xfer(0, 0, 4'd15, 4'd1, 4'd5, 0, 1, 2, -1, 0, 0);
    check(max_low == 6 && ack_cyc == 13, "R6 PIO write ignores code 15", ack_cyc, 13);
  endtask

  task automatic t_wide;
    xfer(1, 1, 4'd2, 0, 0, 1, 0, 3, -1, 0, 0);
    check(beats == 3 && data_err == 0, "R7 wide read word", data_err, 0);
    check(adr_err == 0, "R7 address lines released", adr_err, 0);
    xfer(0, 1, 4'd2, 0, 0, 1, 0, 3, -1, 0, 0);
    check(beats == 3 && data_err == 0 && adr_err == 0, "R7 wide write halves", data_err, 0);
  endtask

  task automatic t_byte;
    xfer(1, 1, 4'd2, 0, 0, 0, 0, 2, -1, 0, 0);
    check(beats == 2 && data_err == 0, "R8 8-bit read", data_err, 0);
    xfer(0, 1, 4'd2, 0, 0, 0, 0, 2, -1, 0, 0);
    check(beats == 2 && data_err == 0, "R8 8-bit write", data_err, 0);
  endtask

  task automatic t_pause;
    xfer(1, 1, 4'd2, 0, 0, 0, 1, 4, 4, 3, 0);
    check(ack_cyc == 15 && beats == 4, "R9 paused transfer length", ack_cyc, 15);
    check(pause_err == 0 && data_err == 0, "R9 inactive during pause", pause_err, 0);
    xfer(1, 1, 4'd15, 0, 0, 0, 1, 6, 3, 2, 0);
    check(ack_cyc == 6 && beats == 6 && pause_err == 0, "R9 paused continuous", ack_cyc, 6);
  endtask

  task automatic t_ignore;
    int hits = 0;
    @(negedge clk);
    chan_en_i = 0; word_cnt_i = 16'd4; req_i = 1;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (ack_o || !cs_n_o) hits++; end
    req_i = 0; chan_en_i = 1;
    check(hits == 0, "R10 disabled channel", hits, 0);
    word_cnt_i = 16'd0; req_i = 1;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (ack_o || !rd_n_o) hits++; end
    req_i = 0;
    check(hits == 0, "R10 zero word count", hits, 0);
  endtask

  task automatic t_latch;
    xfer(1, 1, 4'd3, 0, 0, 0, 1, 3, -1, 0, 1);
    check(max_low == 4 && min_low == 4 && ack_cyc == 14, "R11 timing latched", max_low, 4);
  endtask

  initial begin
    #1 t_reset;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset;
    t_dma_read;
    t_floor;
    t_cont;
    t_pio;
    t_wide;
    t_byte;
    t_pause;
    t_ignore;
    t_latch;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule